// File: doc/BRIEF.md
# Binary32 NaN Classifier and Quieter

This block looks at one binary32 operand and tells whether it is a NaN and, if so, whether that NaN is signaling. A signaling NaN is turned into a quiet NaN on the result port, and an invalid-operation pulse is raised for that operand. Any other operand, quiet NaNs included, leaves the result port as an exact copy of the input.

The meaning of the quiet-indicator bit (the top fraction bit) depends on a mode input. In the 2008 convention a set bit marks a quiet NaN. In the legacy convention a set bit marks a signaling NaN. In legacy mode, clearing that bit could leave a zero fraction, which would encode an infinity. The next lower fraction bit is then set so the result is still a NaN.

The invalid pulse lasts one cycle for each signaling operand. A status register outside the block is expected to collect it as a sticky bit. With the default setting, the outputs are registered one cycle after the operand.

Top module: `fp_nan_quiet`

## Requirements
- R1: `is_nan_o` is 1 exactly when the exponent field (bits 30:23) is all ones and the fraction field (bits 22:0) is nonzero.
- R2: `is_snan_o` is 1 exactly when the operand is a NaN and fraction bit 22 XOR `mode2008_i` equals 1. So with `mode2008_i`=1 a clear bit 22 means signaling, and with `mode2008_i`=0 a set bit 22 means signaling.
- R3: `invalid_o` is 1 for exactly those operands that are signaling NaNs, and 0 for every other operand.
- R4: With `mode2008_i`=1, a signaling NaN produces a result equal to the operand with fraction bit 22 set and every other bit unchanged.
- R5: With `mode2008_i`=0, a signaling NaN produces the operand with fraction bit 22 cleared. If the fraction is then all zeros, fraction bit 21 is set as well (for example, fraction 0x400000 gives fraction 0x200000).
- R6: The sign bit (bit 31) and the exponent field of the result always equal those of the operand.
- R7: For an operand that is not a signaling NaN (quiet NaN, infinity, zero, subnormal or normal), the result equals the operand bit for bit.
- R8: With `REG_OUT`=1, every output reflects the operand and mode presented one clock edge earlier. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 32 | binary32 operand |
| mode2008_i | input | 1 | 1 selects the 2008 NaN convention, 0 selects the legacy convention |
| is_nan_o | output | 1 | Operand is a NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| res_o | output | 32 | Quieted NaN or the operand unchanged |
| invalid_o | output | 1 | Invalid-operation pulse |

## Verification
The bench builds the block with its defaults: an 8-bit exponent, a 23-bit fraction and a registered output (`REG_OUT`=1). This exercises the true binary32 field positions and the one-cycle latency, which the checks sample at the right cycle. Random operands are weighted toward an all-ones exponent, so both NaN classes turn up often in both modes. Directed cases cover the legacy fraction 0x400000, the fractions that differ only in bit 22, both infinities and both zeros.

// File: rtl/fp_nan_pkg.sv
package fp_nan_pkg;

  typedef enum logic {
    NAN_LEGACY = 1'b0,
    NAN_2008   = 1'b1
  } nan_mode_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
    logic frac_hi;
  } nan_class_t;

endpackage

// File: rtl/fp_nan_classify.sv
module fp_nan_classify #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic                    [OP_W-1:0] op_i,
  input  fp_nan_pkg::nan_mode_e              mode_i,
  output fp_nan_pkg::nan_class_t             cls_o
);
  localparam int unsigned QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              frac_nz;

  assign exp_f   = op_i[OP_W-2 -: EXP_W];
  assign frac_f  = op_i[FRAC_W-1:0];
  assign exp_max = &exp_f;
  assign frac_nz = |frac_f;

  always_comb begin
    cls_o.is_nan  = exp_max & frac_nz;
    cls_o.frac_hi = frac_f[QBIT];
    // quiet bit meaning flips with mode
    cls_o.is_snan = cls_o.is_nan & (frac_f[QBIT] ^ (mode_i == fp_nan_pkg::NAN_2008));
  end
endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic                  [OP_W-1:0] op_i,
  input  fp_nan_pkg::nan_mode_e            mode_i,
  input  logic                             snan_i,
  output logic                  [OP_W-1:0] res_o
);
  localparam int unsigned QBIT = FRAC_W - 1;
  localparam int unsigned RBIT = FRAC_W - 2;

  logic [FRAC_W-1:0] frac_in;
  logic [FRAC_W-1:0] frac_set;
  logic [FRAC_W-1:0] frac_clr;
  logic [FRAC_W-1:0] frac_leg;
  logic [FRAC_W-1:0] frac_out;

  assign frac_in = op_i[FRAC_W-1:0];

  always_comb begin
    frac_set       = frac_in;
    frac_set[QBIT] = 1'b1;
    frac_clr       = frac_in;
    frac_clr[QBIT] = 1'b0;
    frac_leg       = frac_clr;
    // keep a NaN from turning into infinity
    if (frac_clr == '0) frac_leg[RBIT] = 1'b1;
  end

  always_comb begin
    if (!snan_i)                              frac_out = frac_in;
    else if (mode_i == fp_nan_pkg::NAN_2008)  frac_out = frac_set;
    else                                      frac_out = frac_leg;
  end

  assign res_o = {op_i[OP_W-1:FRAC_W], frac_out};
endmodule

// File: rtl/fp_nan_outstage.sv
module fp_nan_outstage #(
  parameter int unsigned WIDTH   = 35,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] q_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= d_i;
    end
    assign q_o = q_r;
  end else begin : g_comb
    assign q_o = rst_ni ? d_i : '0;
  end
endmodule

// File: rtl/fp_nan_quiet.sv
module fp_nan_quiet #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned OP_W   = 1 + EXP_W + FRAC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic            mode2008_i,
  output logic            is_nan_o,
  output logic            is_snan_o,
  output logic [OP_W-1:0] res_o,
  output logic            invalid_o
);
  localparam int unsigned STG_W = OP_W + 3;

  fp_nan_pkg::nan_mode_e  mode;
  fp_nan_pkg::nan_class_t cls;
  logic [OP_W-1:0]        res_c;
  logic [STG_W-1:0]       stg_d;
  logic [STG_W-1:0]       stg_q;

  assign mode = mode2008_i ? fp_nan_pkg::NAN_2008 : fp_nan_pkg::NAN_LEGACY;

  fp_nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op_i   (op_i),
    .mode_i (mode),
    .cls_o  (cls)
  );

  fp_nan_quieter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_qt (
    .op_i   (op_i),
    .mode_i (mode),
    .snan_i (cls.is_snan),
    .res_o  (res_c)
  );

  assign stg_d = {cls.is_nan, cls.is_snan, cls.is_snan, res_c};

  fp_nan_outstage #(.WIDTH(STG_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (stg_d),
    .q_o    (stg_q)
  );

  assign is_nan_o  = stg_q[STG_W-1];
  assign is_snan_o = stg_q[STG_W-2];
  assign invalid_o = stg_q[STG_W-3];
  assign res_o     = stg_q[OP_W-1:0];
endmodule

// File: rtl/fp_nan_quiet_chk.sv
module fp_nan_quiet_chk #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned FRAC_W  = 23,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned OP_W   = 1 + EXP_W + FRAC_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic            mode2008_i,
  input logic            is_nan_o,
  input logic            is_snan_o,
  input logic [OP_W-1:0] res_o,
  input logic            invalid_o
);
  localparam int unsigned QBIT = FRAC_W - 1;

  logic [OP_W-1:0] op_q;
  logic            mode_q;
  logic [OP_W-1:0] src;
  logic            src_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      mode_q <= 1'b0;
    end else begin
      op_q   <= op_i;
      mode_q <= mode2008_i;
    end
  end

  assign src      = REG_OUT ? op_q : op_i;
  assign src_mode = REG_OUT ? mode_q : mode2008_i;

  assert_nan_detect_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 is_nan_o == ((&src[OP_W-2 -: EXP_W]) && (src[FRAC_W-1:0] != '0)));

  assert_snan_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 is_snan_o == (is_nan_o && (src[QBIT] ^ src_mode)));

  assert_flag_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o == is_snan_o);

  assert_quiet_2008_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (is_snan_o && src_mode) |-> res_o == (src | (OP_W'(1) << QBIT)));

  assert_quiet_legacy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (is_snan_o && !src_mode) |-> (!res_o[QBIT] && res_o[FRAC_W-1:0] != '0));

  assert_keep_sign_exp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 res_o[OP_W-1:FRAC_W] == src[OP_W-1:FRAC_W]);

  assert_passthru_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 !is_snan_o |-> res_o == src);
endmodule

bind fp_nan_quiet fp_nan_quiet_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .REG_OUT(REG_OUT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .mode2008_i (mode2008_i),
  .is_nan_o   (is_nan_o),
  .is_snan_o  (is_snan_o),
  .res_o      (res_o),
  .invalid_o  (invalid_o)
);

// File: tb/tb_fp_nan_quiet.sv
module tb_fp_nan_quiet;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op_i = '0;
  logic        mode2008_i = 1'b0;
  logic        is_nan_o, is_snan_o, invalid_o;
  logic [31:0] res_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  fp_nan_quiet dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .mode2008_i(mode2008_i),
    .is_nan_o(is_nan_o), .is_snan_o(is_snan_o), .res_o(res_o), .invalid_o(invalid_o)
  );

  function automatic bit f_nan(input logic [31:0] x);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic bit f_snan(input logic [31:0] x, input bit m);
    return f_nan(x) && (m ? !x[22] : x[22]);
  endfunction

  function automatic logic [31:0] f_res(input logic [31:0] x, input bit m);
    logic [31:0] r;
    r = x;
    if (f_snan(x, m)) begin
      if (m) r[22] = 1'b1;
      else begin
        r[22] = 1'b0;
        if (r[22:0] == 0) r[21] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, outputs valid at next negedge (one register)
  task automatic apply(input logic [31:0] x, input bit m);
    op_i = x;
    mode2008_i = m;
    @(negedge clk_i);
    chk("R1", {31'd0, is_nan_o}, {31'd0, f_nan(x)});
    chk("R2", {31'd0, is_snan_o}, {31'd0, f_snan(x, m)});
    chk("R3", {31'd0, invalid_o}, {31'd0, f_snan(x, m)});
    if (f_snan(x, m)) chk(m ? "R4" : "R5", res_o, f_res(x, m));
    else              chk("R7", res_o, x);
    chk("R6", {23'd0, res_o[31:23]}, {23'd0, x[31:23]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    op_i = 32'h7fa0_0001;
    mode2008_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 reset res", res_o, 32'h0);
    chk("R8 reset flags", {29'd0, is_nan_o, is_snan_o, invalid_o}, 32'h0);
    rst_ni = 1'b1;

    // R8 latency: output must still hold old value before the edge
    op_i = 32'h7f80_0001; mode2008_i = 1'b1;
    #1;
    chk("R8 latency", {31'd0, invalid_o}, 32'd0);
    @(negedge clk_i);
    chk("R8 after edge", {31'd0, invalid_o}, 32'd1);

    for (int m = 0; m < 2; m++) begin
      apply(32'h7fc0_0000, bit'(m));  // frac 0x400000: legacy corner R5
      apply(32'hffc0_0000, bit'(m));
      apply(32'h7f80_0001, bit'(m));
      apply(32'hff80_0001, bit'(m));
      apply(32'h7fff_ffff, bit'(m));
      apply(32'h7fbf_ffff, bit'(m));
      apply(32'h7f80_0000, bit'(m));  // +inf
      apply(32'hff80_0000, bit'(m));  // -inf
      apply(32'h0000_0000, bit'(m));
      apply(32'h8000_0000, bit'(m));
      apply(32'h3f80_0000, bit'(m));
      apply(32'h0040_0000, bit'(m));  // subnormal with bit 22
      apply(32'h7f7f_ffff, bit'(m));
    end

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      x = $urandom;
      case ($urandom % 4)
        0, 1: x[30:23] = 8'hff;
        2:    begin x[30:23] = 8'hff; x[21:0] = ($urandom % 2) ? 22'd0 : 22'd1; end
        default: ;
      endcase
      apply(x, bit'($urandom % 2));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule